// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a small set of hardware lock tokens that two independent agents, one on a left port and one on a right port, use to arbitrate shared resources. Each port has an active-low semaphore select, an active-low array enable, an active-low write strobe, a semaphore address, a write data bus and a read data bus. A semaphore cycle takes place only when the select is low and the array enable is high. On such a cycle, a write with data bit 0 cleared asks for a token and a write with data bit 0 set gives it back. A read reports whether the reading port currently owns the addressed token.

A port that asks for a token held by the other side is queued. Ownership does not change until the holder lets go. The token then moves straight to the waiting port, so that port never needs to poll and re-request. Read data is registered: the status word appears on the read bus in the cycle after the read. All bits of that word are copies of one status bit. When a port is not reading, its read bus rests at all ones.

Top module: `sem_dual_port_unit`

## Requirements
- R1: There are NUM_SEM (default 8) independent tokens, selected by the address bits (semaphore n at address n). An operation on one token leaves every other token unchanged.
- R2: A port performs a semaphore operation only in a cycle where its select is low and its array enable is high. A write made with select high, or with array enable low, changes no ownership and leaves no queued request.
- R3: A write to a free token with data bit 0 equal to 0 makes the writing port its owner. Data bits above bit 0 are ignored.
- R4: A read (write strobe high) places the status on every bit of the read bus one clock after the read cycle. The word is all zeros when the reading port owns the token and all ones otherwise. In a cycle with no read, the read bus is all ones.
- R5: A request (write of 0) to a token owned by the other port leaves ownership unchanged and is queued. A request by the current owner has no effect.
- R6: When the owner writes 1 while the other port has a queued request, the other port becomes the owner in the next cycle.
- R7: When the owner writes 1 and the other port has no queued request, the token becomes free, and both ports read 1.
- R8: If both ports request the same free token in the same cycle, the left port becomes the owner and the right request is queued.
- R9: A write of 1 by a port that does not own the token cancels any request that port has queued on it.
- R10: After reset every token is free, no request is queued, and both read buses are all ones.
- R11: If the owner releases a token in the same cycle as the other port requests it, ownership passes to the requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_arr_n | input | 1 | Left array enable, active low; must be high for a semaphore cycle |
| l_wr_n | input | 1 | Left write strobe, low = write, high = read |
| l_addr | input | 3 | Left semaphore address |
| l_wdata | input | 18 | Left write data, only bit 0 is used |
| l_rdata | output | 18 | Left registered status word |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_arr_n | input | 1 | Right array enable, active low; must be high for a semaphore cycle |
| r_wr_n | input | 1 | Right write strobe, low = write, high = read |
| r_addr | input | 3 | Right semaphore address |
| r_wdata | input | 18 | Right write data, only bit 0 is used |
| r_rdata | output | 18 | Right registered status word |

## Verification
Assertions inside each token cell check the ownership transitions on every cycle. These are: a queued request held while the other side owns the token, a direct handover on release, return to free when no one waits, the left-first tie rule, cancellation of a queued request, and a queue bit existing only while the opposite port owns the token. The read-port assertions check on every cycle that a read returns a uniform word and that an idle bus rests at all ones. Only the bench's scenarios show the rest. Those are the separation between tokens, the gating by select and array enable, that upper data bits are ignored, the reset state seen through reads, and the complete request, wait and handover sequences observed from both ports.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } sem_cell_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 18
) (
    input  logic              sem_n,
    input  logic              arr_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_SEM-1:0] take,
    output logic [NUM_SEM-1:0] give,
    output logic              rd
);

    logic acc;
    logic wr;
    logic unused_hi;

    // semaphore cycle: select low, array enable high
    assign acc = ~sem_n & arr_n;
    assign wr  = acc & ~wr_n;
    assign rd  = acc & wr_n;

    // only bit 0 carries meaning on writes
    assign unused_hi = ^wdata[DATA_W-1:1];

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        logic hit;
        assign hit     = wr && (addr == ADDR_W'(i));
        assign take[i] = hit & ~wdata[0];
        assign give[i] = hit &  wdata[0];
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_take,
    input  logic l_give,
    input  logic r_take,
    input  logic r_give,
    output logic l_holds,
    output logic r_holds
);

    sem_cell_t c_d, c_q;
    logic want_l, want_r;

    always_comb begin
        want_l = (c_q.wait_l | l_take) & ~l_give;
        want_r = (c_q.wait_r | r_take) & ~r_give;
        c_d    = c_q;
        case (c_q.owner)
            OWN_LEFT: begin
                c_d.wait_l = 1'b0;
                if (l_give) begin
                    c_d.owner  = want_r ? OWN_RIGHT : OWN_NONE;
                    c_d.wait_r = 1'b0;
                end else begin
                    c_d.wait_r = want_r;
                end
            end
            OWN_RIGHT: begin
                c_d.wait_r = 1'b0;
                if (r_give) begin
                    c_d.owner  = want_l ? OWN_LEFT : OWN_NONE;
                    c_d.wait_l = 1'b0;
                end else begin
                    c_d.wait_l = want_l;
                end
            end
            default: begin
                c_d.wait_l = 1'b0;
                c_d.wait_r = 1'b0;
                c_d.owner  = OWN_NONE;
                if (want_l) begin
                    c_d.owner  = OWN_LEFT;
                    c_d.wait_r = want_r;
                end else if (want_r) begin
                    c_d.owner  = OWN_RIGHT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign l_holds = (c_q.owner == OWN_LEFT);
    assign r_holds = (c_q.owner == OWN_RIGHT);

    // R5
    req_held_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_LEFT && r_take && !l_give) |=> (c_q.owner == OWN_LEFT && c_q.wait_r));

    // R5
    req_held_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_RIGHT && l_take && !r_give) |=> (c_q.owner == OWN_RIGHT && c_q.wait_l));

    // R6
    handover_to_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_LEFT && l_give && c_q.wait_r && !r_give) |=> (c_q.owner == OWN_RIGHT));

    // R6
    handover_to_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_RIGHT && r_give && c_q.wait_l && !l_give) |=> (c_q.owner == OWN_LEFT));

    // R7
    release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_LEFT && l_give && !c_q.wait_r && !r_take)
        |=> (c_q.owner == OWN_NONE && !c_q.wait_l && !c_q.wait_r));

    // R8
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_NONE && l_take && r_take) |=> (c_q.owner == OWN_LEFT && c_q.wait_r));

    // R9
    cancel_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_LEFT && r_give) |=> !c_q.wait_r);

    // R5
    queue_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.wait_r |-> c_q.owner == OWN_LEFT) and (c_q.wait_l |-> c_q.owner == OWN_RIGHT));

    // R11
    swap_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owner == OWN_RIGHT && r_give && l_take) |=> (c_q.owner == OWN_LEFT));

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SEM-1:0] holds,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              stat;

    always_comb begin
        stat    = 1'b1;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (addr == ADDR_W'(i)) stat = ~holds[i];
        end
        rdata_d = rd ? {DATA_W{stat}} : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '1;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R4
    uniform_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (rdata_q == '0 || rdata_q == '1));

    // R4
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata_q == '1));

endmodule

// File: rtl/sem_dual_port_unit.sv
module sem_dual_port_unit #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_n,
    input  logic              l_arr_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_arr_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] l_take, l_give, r_take, r_give;
    logic [NUM_SEM-1:0] l_holds, r_holds;
    logic               l_rd, r_rd;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_l (
        .sem_n (l_sem_n),
        .arr_n (l_arr_n),
        .wr_n  (l_wr_n),
        .addr  (l_addr),
        .wdata (l_wdata),
        .take  (l_take),
        .give  (l_give),
        .rd    (l_rd)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_r (
        .sem_n (r_sem_n),
        .arr_n (r_arr_n),
        .wr_n  (r_wr_n),
        .addr  (r_addr),
        .wdata (r_wdata),
        .take  (r_take),
        .give  (r_give),
        .rd    (r_rd)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_cell i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .l_take  (l_take[i]),
            .l_give  (l_give[i]),
            .r_take  (r_take[i]),
            .r_give  (r_give[i]),
            .l_holds (l_holds[i]),
            .r_holds (r_holds[i])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_l (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (l_rd),
        .addr  (l_addr),
        .holds (l_holds),
        .rdata (l_rdata)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_r (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (r_rd),
        .addr  (r_addr),
        .holds (r_holds),
        .rdata (r_rdata)
    );

    // R1
    exclusive_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_holds & r_holds) == '0);

endmodule

// File: tb/test_sem_dual_port_unit.sv
module test_sem_dual_port_unit;

    localparam int DW = 18;
    localparam int K_IDLE  = 0;
    localparam int K_RD    = 1;
    localparam int K_TAKE  = 2;
    localparam int K_GIVE  = 3;
    localparam int K_NOARR = 4;
    localparam int K_NOSEL = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sem_n = 1'b1, l_arr_n = 1'b1, l_wr_n = 1'b1;
    logic [2:0]    l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          r_sem_n = 1'b1, r_arr_n = 1'b1, r_wr_n = 1'b1;
    logic [2:0]    r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;

    always #2.5 clk = ~clk;

    sem_dual_port_unit i_sem_dual_port_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sem_n(l_sem_n), .l_arr_n(l_arr_n), .l_wr_n(l_wr_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_arr_n(r_arr_n), .r_wr_n(r_wr_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    typedef struct {
        bit            right;
        logic [DW-1:0] exp;
        int            due;
        string         tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected words once they are due
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [DW-1:0] got;
                it  = sb.pop_front();
                got = it.right ? r_rdata : l_rdata;
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s port: got %h expected %h",
                             it.tag, it.right ? "right" : "left", got, it.exp);
                end
            end
        end
    end

    task automatic set_port(input bit right, input int kind, input int a);
        logic s, e, w;
        logic [DW-1:0] d;
        s = 1'b1; e = 1'b1; w = 1'b1; d = '0;
        case (kind)
            K_RD:    begin s = 1'b0; end
            K_TAKE:  begin s = 1'b0; w = 1'b0; d = {{(DW-1){1'b1}}, 1'b0}; end
            K_GIVE:  begin s = 1'b0; w = 1'b0; d = {{(DW-1){1'b0}}, 1'b1}; end
            K_NOARR: begin s = 1'b0; e = 1'b0; w = 1'b0; d = '0; end
            K_NOSEL: begin s = 1'b1; w = 1'b0; d = '0; end
            default: ;
        endcase
        if (right) begin
            r_sem_n = s; r_arr_n = e; r_wr_n = w; r_addr = 3'(a); r_wdata = d;
        end else begin
            l_sem_n = s; l_arr_n = e; l_wr_n = w; l_addr = 3'(a); l_wdata = d;
        end
    endtask

    // driver: one cycle of stimulus on both ports, expected words into the queue
    task automatic op(input string tag, input int lk, input int la,
                      input int rk, input int ra, input int el, input int er);
        item_t it;
        set_port(1'b0, lk, la);
        set_port(1'b1, rk, ra);
        if (el >= 0) begin
            it.right = 1'b0; it.exp = (el != 0) ? '1 : '0; it.due = cyc + 1; it.tag = tag;
            sb.push_back(it);
        end
        if (er >= 0) begin
            it.right = 1'b1; it.exp = (er != 0) ? '1 : '0; it.due = cyc + 1; it.tag = tag;
            sb.push_back(it);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs at rest during reset
        n_chk++;
        if (l_rdata !== '1 || r_rdata !== '1) begin
            n_bad++;
            $display("FAIL R10 in reset: got %h/%h expected all ones", l_rdata, r_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);

        op("R10 free after reset", K_RD, 0, K_RD, 0, 1, 1);
        op("R10 free after reset", K_RD, 7, K_RD, 5, 1, 1);
        op("R4 idle bus", K_IDLE, 0, K_IDLE, 0, 1, 1);

        // R3, R4: take with noisy upper bits, read both sides
        op("R3 take", K_TAKE, 0, K_IDLE, 0, -1, -1);
        op("R3 R4 owner view", K_RD, 0, K_RD, 0, 0, 1);

        // R5: right queued behind left
        op("R5 request", K_IDLE, 0, K_TAKE, 0, -1, -1);
        op("R5 unchanged", K_RD, 0, K_RD, 0, 0, 1);

        // R6: left release hands token to right
        op("R6 release", K_GIVE, 0, K_IDLE, 0, -1, -1);
        op("R6 handover", K_RD, 0, K_RD, 0, 1, 0);

        // R7: right release with nobody waiting
        op("R7 release", K_IDLE, 0, K_GIVE, 0, -1, -1);
        op("R7 free", K_RD, 0, K_RD, 0, 1, 1);

        // R1: independence of tokens
        op("R1 take 3", K_TAKE, 3, K_IDLE, 0, -1, -1);
        op("R1 neighbours", K_RD, 2, K_RD, 3, 1, 1);
        op("R1 neighbours", K_RD, 3, K_RD, 4, 0, 1);

        // R2: gated writes do nothing
        op("R2 gated", K_NOARR, 5, K_NOSEL, 6, -1, -1);
        op("R2 no owner", K_RD, 5, K_RD, 6, 1, 1);
        op("R2 no queue", K_IDLE, 0, K_TAKE, 5, -1, -1);
        op("R2 right gets 5", K_RD, 5, K_RD, 5, 1, 0);

        // R8: tie on a free token
        op("R8 tie", K_TAKE, 6, K_TAKE, 6, -1, -1);
        op("R8 left wins", K_RD, 6, K_RD, 6, 0, 1);
        op("R8 release", K_GIVE, 6, K_IDLE, 0, -1, -1);
        op("R8 right was queued", K_RD, 6, K_RD, 6, 1, 0);
        op("R8 free", K_IDLE, 0, K_GIVE, 6, -1, -1);
        op("R8 free", K_RD, 6, K_RD, 6, 1, 1);

        // R9: right cancels its queued request on token 3
        op("R9 request", K_IDLE, 0, K_TAKE, 3, -1, -1);
        op("R9 cancel", K_IDLE, 0, K_GIVE, 3, -1, -1);
        op("R9 release", K_GIVE, 3, K_IDLE, 0, -1, -1);
        op("R9 token free", K_RD, 3, K_RD, 3, 1, 1);

        // R11: release and request in the same cycle
        op("R11 right takes", K_IDLE, 0, K_TAKE, 7, -1, -1);
        op("R11 swap", K_TAKE, 7, K_GIVE, 7, -1, -1);
        op("R11 left owns", K_RD, 7, K_RD, 7, 0, 1);

        // R5: owner re-request is harmless
        op("R5 take 1", K_TAKE, 1, K_IDLE, 0, -1, -1);
        op("R5 take 1 again", K_TAKE, 1, K_IDLE, 0, -1, -1);
        op("R5 still owner", K_RD, 1, K_RD, 1, 0, 1);

        op("drain", K_IDLE, 0, K_IDLE, 0, -1, -1);
        op("drain", K_IDLE, 0, K_IDLE, 0, -1, -1);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule